// File: doc/BRIEF.md
# Bit-Masked Control Word for a PHY Configuration Port

This block holds a 16-bit control word behind a 32-bit bus word. Every bus write carries its own per-bit write enable in the upper half-word. Bit x of the stored word takes bit x of the write only when bit x+16 of the same write is 1. Software can therefore flip one field, or even one bit, without first reading the register back, and two agents writing different fields cannot overwrite each other's bits.

The stored word drives a PHY configuration port directly. Bit 0 is the configuration write strobe. Bits 6:1 carry a 6-bit configuration address. Bits 10:7 carry a 4-bit configuration data value. The upper mask half is never stored. A read returns the stored word in the low half and zeros in the high half.

Top module: `hw_mask_cfg_reg`

## Requirements
- R1: While `rst_n` is low the stored word is 0, so `cfg_strobe`, `cfg_addr`, `cfg_data` and `ctrl_word` are 0, and `rd_data` is 0.
- R2: On a write (`wr_en` high at a rising clock edge), bit x of the stored word (x in 0..15) takes `wr_data[x]` when `wr_data[x+16]` is 1. The new value is visible on the outputs after that same edge.
- R3: On a write, every stored bit whose enable bit `wr_data[x+16]` is 0 keeps its previous value.
- R4: A write whose upper half-word is 0 is accepted and leaves the stored word unchanged.
- R5: `cfg_strobe` equals stored bit 0, and only `wr_data[16]` can enable a change to it.
- R6: `cfg_addr` equals stored bits 6:1, with bit 1 as its LSB.
- R7: `cfg_data` equals stored bits 10:7, with bit 7 as its LSB.
- R8: A write with upper half 0x07FE updates bits 10:1 (address and data together) in one write and leaves bit 0 unchanged.
- R9: A read (`rd_en` high at a rising edge) loads `rd_data` with {16'h0000, stored word} as it was before that edge, so a write in the same cycle is not yet visible. `rd_data[31:16]` is always 0, and `rd_data` holds its value when there is no read.
- R10: With `wr_en` low the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | [31:16] bit enables, [15:0] values |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 32 | Registered readback, upper half zero |
| ctrl_word | output | 16 | Stored control word |
| cfg_strobe | output | 1 | PHY configuration write strobe (bit 0) |
| cfg_addr | output | 6 | PHY configuration address (bits 6:1) |
| cfg_data | output | 4 | PHY configuration data (bits 10:7) |

## Verification
The hardest case to reach is a write and a read in the same cycle. The read must return the word from before the write, while the outputs already show the merged value. The bench drives both strobes in one cycle, with a mask that changes bits which differ from the stored word. The reference model records the expected read word before it applies the write. The bench also uses sparse masks whose set bits fall on stored bits of both polarities. With these masks, a design that ignores the mask, or that shifts it by one bit, produces a wrong word.

// File: rtl/hw_mask_cfg_reg.sv
module hw_mask_cfg_reg #(
  parameter int HALF_W = 16,
  parameter int ADDR_LSB = 1,
  parameter int ADDR_W = 6,
  parameter int DATA_LSB = 7,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2*HALF_W-1:0] wr_data,
  input  logic                rd_en,
  output logic [2*HALF_W-1:0] rd_data,
  output logic [HALF_W-1:0]   ctrl_word,
  output logic                cfg_strobe,
  output logic [ADDR_W-1:0]   cfg_addr,
  output logic [DATA_W-1:0]   cfg_data
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] ctrl_q;
  logic [HALF_W-1:0] bit_en;
  logic [HALF_W-1:0] bit_val;

  assign bit_en  = wr_data[WORD_W-1:HALF_W];
  assign bit_val = wr_data[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en)
      ctrl_q <= (ctrl_q & ~bit_en) | (bit_val & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= {{HALF_W{1'b0}}, ctrl_q};
  end

  assign ctrl_word  = ctrl_q;
  assign cfg_strobe = ctrl_q[0];
  assign cfg_addr   = ctrl_q[ADDR_LSB +: ADDR_W];
  assign cfg_data   = ctrl_q[DATA_LSB +: DATA_W];
endmodule

// File: rtl/hw_mask_cfg_reg_chk.sv
module hw_mask_cfg_reg_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [2*HALF_W-1:0] wr_data,
  input logic                rd_en,
  input logic [2*HALF_W-1:0] rd_data,
  input logic [HALF_W-1:0]   ctrl_word
);
  assert_unmasked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_word ^ $past(ctrl_word)) & ~$past(wr_data[2*HALF_W-1:HALF_W])) == '0);

  assert_masked_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_word ^ $past(wr_data[HALF_W-1:0])) & $past(wr_data[2*HALF_W-1:HALF_W])) == '0);

  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2*HALF_W-1:HALF_W] == '0) |=> $stable(ctrl_word));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_word));

  assert_read_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == {{HALF_W{1'b0}}, $past(ctrl_word)});

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  always_comb begin
    if (rst_n) assert_upper_zero_R9: assert (rd_data[2*HALF_W-1:HALF_W] == '0);
  end
endmodule

bind hw_mask_cfg_reg hw_mask_cfg_reg_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ctrl_word(ctrl_word)
);

// File: tb/test_hw_mask_cfg_reg.sv
module test_hw_mask_cfg_reg;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] ctrl_word;
  logic cfg_strobe;
  logic [5:0] cfg_addr;
  logic [3:0] cfg_data;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] model = '0;
  logic [31:0] exp_q[$];
  logic rd_seen = 0;

  always #10 clk = ~clk;

  hw_mask_cfg_reg i_hw_mask_cfg_reg (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // driver: one bus cycle, optional write and read together
  task automatic cyc(bit w, logic [31:0] d, bit r);
    wr_en = w; wr_data = d; rd_en = r;
    if (r) exp_q.push_back({16'h0, model});
    if (w) model = (model & ~d[31:16]) | (d[15:0] & d[31:16]);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic fields(string tag);
    chk({tag, " word"}, {16'h0, ctrl_word}, {16'h0, model});
    chk("R5 strobe", {31'h0, cfg_strobe}, {31'h0, model[0]});
    chk("R6 addr", {26'h0, cfg_addr}, {26'h0, model[6:1]});
    chk("R7 data", {28'h0, cfg_data}, {28'h0, model[10:7]});
  endtask

  // monitor
  always @(posedge clk) rd_seen <= rd_en && rst_n;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) chk("R9 unexpected read", rd_data, '0);
    else chk("R9 readback", rd_data, exp_q.pop_front());
  end

  initial begin
    #(20 * 50000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset word", {16'h0, ctrl_word}, 32'h0);
    chk("R1 reset read", rd_data, 32'h0);
    rst_n = 1;
    @(negedge clk);
    cyc(0, '0, 1); @(negedge clk);
    // R2 full write
    cyc(1, 32'hFFFF_A5C3, 0); fields("R2 full");
    // R3 sparse mask over mixed bits
    cyc(1, 32'h0F0F_5A5A, 0); fields("R3 sparse");
    cyc(1, 32'h8421_FFFF, 0); fields("R3 single bits");
    // R4 zero mask
    cyc(1, 32'h0000_FFFF, 1); fields("R4 zero mask"); @(negedge clk);
    // R5 strobe pulse
    cyc(1, 32'h0001_0001, 0); fields("R5 set");
    cyc(1, 32'hFFFE_0000, 0); fields("R5 untouched");
    cyc(1, 32'h0001_0000, 0); fields("R5 clear");
    // R6 address alone
    cyc(1, 32'h007E_0020, 0); fields("R6 addr 0x10");
    // R7 data alone
    cyc(1, 32'h0780_0400, 0); fields("R7 data 0x8");
    // R8 wide update of bits 10:1
    cyc(1, 32'h0001_0001, 0);
    cyc(1, 32'h07FE_0246, 0); fields("R8 wide");
    chk("R8 bit0 kept", {31'h0, cfg_strobe}, 32'h1);
    // R9 read with same-cycle write
    cyc(1, 32'hFFFF_1234, 1); @(negedge clk); fields("R9 after rw");
    cyc(0, '0, 1); @(negedge clk);
    // R10 no write: data on bus ignored
    wr_data = 32'hFFFF_0000;
    @(negedge clk); @(negedge clk);
    fields("R10 idle");
    cyc(0, '0, 1); @(negedge clk);
    chk("R9 hold", rd_data, {16'h0, model});
    // R1 reset mid-run
    rst_n = 0; model = '0; @(negedge clk);
    fields("R1 rereset");
    chk("R1 rereset read", rd_data, 32'h0);
    rst_n = 1; @(negedge clk);
    if (exp_q.size() != 0) chk("R9 missing reads", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule